// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a single raw NAND flash interface through one complete operation each time software starts it. Software loads two opcode registers, two address registers, a 32-bit data holding register and two timing registers. It then writes a command word. The command word selects which phases run: a first opcode, a run of address bytes, a short programmed-I/O data phase of up to four bytes, a second opcode, and a wait on the ready/busy line. Each phase has its own enable bit. A single flag chooses whether the second opcode goes before or after the data phase.

Each write or read strobe has a low time and a high time, and every one of these lengths is a register field plus one cycle. The busy-wait phase and the address-to-data gap also have their own programmable counts. When the last enabled phase ends, a done flag is set. Software clears this flag by writing one to it. The flag drives the interrupt output only when both its own enable and a global enable are set. Writing an all-zero command word while the block is running aborts the operation.

Top module: `nand_cmd_seq`

Register map (word index on `reg_addr`): 0 command, 1 status, 2 interrupt enable, 3 strobe timing, 4 address-to-data gap, 5 first opcode, 6 second opcode, 7 address low word, 8 address high word, 9 data holding.

## Requirements
- R1: Writing word 0 with bit 31 set and the block idle starts an operation. With bit 25 clear, the enabled phases run in this order: first opcode (bit 30), address (bit 29), second opcode (bit 26), busy-wait (bit 24), data (bit 28).
- R2: With bit 25 set, the order becomes: first opcode, address, data, second opcode, busy-wait.
- R3: The address phase sends command bits 2:0 plus one bytes. The bytes are taken least-significant first, from word 7 and then from word 8, with ALE high and CLE low.
- R4: The first opcode byte comes from word 5 and the second from word 6. Both are sent with CLE high and ALE low.
- R5: The data phase moves bits 21:20 plus one bytes. Bit 27 set means transmit: bytes are taken from word 9, low byte first. Bit 27 clear means receive: sampled bytes are written into word 9 at the same positions, and the bytes not received keep their value.
- R6: While the block is busy, exactly the chip-enable line selected by command bits 18:16 is driven low. All chip-enable lines are high when the block is idle.
- R7: Busy-wait waits timing bits 19:16 plus one cycles. It then holds until the ready input is high, and no later phase starts before that.
- R8: A write strobe is low for timing bits 3:0 plus one cycles and high for bits 5:4 plus one cycles. A read strobe is low for bits 11:8 plus one and high for bits 13:12 plus one. The two strobes are never low together, and the output data is stable while the write strobe is low.
- R9: Completion sets status bit 1. Writing one to that bit clears it. The interrupt output is high only when status bit 1, enable bit 1 and global enable bit 0 are all set.
- R10: Writing zero to word 0 while busy stops the operation at once. All strobes and chip enables go idle and status bit 1 is not set.
- R11: Status bit 0 reads one from start to completion. While it is one, writes to words 0 (other than zero), 5, 6, 7, 8 and 9 have no effect.
- R12: When a transmit data phase directly follows the address phase, an extra idle gap of word 4 bits 3:0 plus one cycles is inserted after the last address strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | NCE | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy | input | 1 | Ready (high) / busy (low) from flash |

## Verification
The assertions check the bus on every cycle. They cover one-hot chip enable, CLE and ALE never both high, the two strobes never low together, and data held steady under the write strobe. They also check that an abort leaves the block idle without completion, and that completion is never flagged while a phase is still running. Phase ordering, the exact byte values and their order, the pulse and gap lengths, the busy-wait delay, receive packing, ignored writes and interrupt gating can only be shown by the bench's scenarios. For these, the bench records every strobe and compares it with a model of the requirements.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int NCE = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic [NCE-1:0] nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [7:0]     nand_dq_o,
  output logic           nand_dq_oe,
  input  logic [7:0]     nand_dq_i,
  input  logic           nand_rdy
);
  localparam int CSW = $clog2(NCE);

  typedef enum logic [3:0] {P_IDLE, P_CMD1, P_ADDR, P_CMD2, P_WB, P_RDY, P_ADL, P_DATA, P_DONE} phase_t;

  phase_t      phase, nxt, first;
  logic [31:0] cmd_q, adr1, adr2, hold;
  logic [7:0]  opc1, opc2;
  logic [19:0] tim1;
  logic [3:0]  tim2, cnt;
  logic [1:0]  ien;
  logic        done_q, hi;
  logic [2:0]  bidx;

  function automatic phase_t succ(phase_t p, logic lt);
    case (p)
      P_IDLE:  return P_CMD1;
      P_CMD1:  return P_ADDR;
      P_ADDR:  return lt ? P_DATA : P_CMD2;
      P_CMD2:  return P_WB;
      P_WB:    return lt ? P_DONE : P_DATA;
      P_DATA:  return lt ? P_CMD2 : P_DONE;
      default: return P_DONE;
    endcase
  endfunction

  function automatic logic on(phase_t p, logic [31:0] c);
    case (p)
      P_CMD1:  return c[30];
      P_ADDR:  return c[29];
      P_CMD2:  return c[26];
      P_WB:    return c[24];
      P_DATA:  return c[28];
      P_DONE:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic phase_t next_ph(phase_t p, logic [31:0] c);
    phase_t q;
    logic   found;
    q = p;
    found = 1'b0;
    for (int i = 0; i < 6; i++)
      if (!found) begin
        q = succ(q, c[25]);
        if (on(q, c)) found = 1'b1;
      end
    return q;
  endfunction

  wire busy   = (phase != P_IDLE);
  wire tx     = cmd_q[27];
  wire is_rd  = (phase == P_DATA) && !tx;
  wire is_wr  = (phase == P_CMD1) || (phase == P_CMD2) || (phase == P_ADDR) ||
                ((phase == P_DATA) && tx);
  wire strobe = is_wr || is_rd;

  wire [3:0] lo_len = is_rd ? tim1[11:8] : tim1[3:0];
  wire [3:0] hi_len = is_rd ? {2'b00, tim1[13:12]} : {2'b00, tim1[5:4]};
  wire [2:0] nb_m1  = (phase == P_ADDR) ? cmd_q[2:0] :
                      (phase == P_DATA) ? {1'b0, cmd_q[21:20]} : 3'd0;

  wire adv = (strobe && hi && cnt == hi_len && bidx == nb_m1) ||
             (phase == P_WB  && cnt == tim1[19:16]) ||
             (phase == P_RDY && nand_rdy) ||
             (phase == P_ADL && cnt == tim2);

  always_comb begin
    case (phase)
      P_WB:    nxt = P_RDY;
      P_RDY:   nxt = next_ph(P_WB, cmd_q);
      P_ADL:   nxt = P_DATA;
      default: nxt = next_ph(phase, cmd_q);
    endcase
    if (phase == P_ADDR && nxt == P_DATA && tx) nxt = P_ADL;
    first = next_ph(P_IDLE, reg_wdata);
  end

  wire wr_cmd = reg_wr && reg_addr == RAW'(0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; cmd_q <= '0; adr1 <= '0; adr2 <= '0; hold <= '0;
      opc1 <= '0; opc2 <= '0; tim1 <= '0; tim2 <= '0; ien <= '0;
      done_q <= 1'b0; hi <= 1'b0; cnt <= '0; bidx <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RAW'(1): if (reg_wdata[1]) done_q <= 1'b0;
          RAW'(2): ien  <= reg_wdata[1:0];
          RAW'(3): tim1 <= reg_wdata[19:0];
          RAW'(4): tim2 <= reg_wdata[3:0];
          RAW'(5): if (!busy) opc1 <= reg_wdata[7:0];
          RAW'(6): if (!busy) opc2 <= reg_wdata[7:0];
          RAW'(7): if (!busy) adr1 <= reg_wdata;
          RAW'(8): if (!busy) adr2 <= reg_wdata;
          RAW'(9): if (!busy) hold <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_cmd && busy && reg_wdata == 32'd0) begin
        phase <= P_IDLE;
        hi <= 1'b0; cnt <= '0; bidx <= '0;
      end else if (wr_cmd && !busy) begin
        cmd_q <= reg_wdata;
        hi <= 1'b0; cnt <= '0; bidx <= '0;
        if (reg_wdata[31]) begin
          if (first == P_DONE) done_q <= 1'b1;
          else phase <= first;
        end
      end else if (busy) begin
        if (adv) begin
          phase <= (nxt == P_DONE) ? P_IDLE : nxt;
          if (nxt == P_DONE) done_q <= 1'b1;
          hi <= 1'b0; cnt <= '0; bidx <= '0;
        end else if (strobe) begin
          if (!hi) begin
            if (cnt == lo_len) begin
              hi <= 1'b1; cnt <= '0;
              if (is_rd) hold[{bidx[1:0], 3'b000} +: 8] <= nand_dq_i;
            end else cnt <= cnt + 4'd1;
          end else begin
            if (cnt == hi_len) begin
              hi <= 1'b0; cnt <= '0; bidx <= bidx + 3'd1;
            end else cnt <= cnt + 4'd1;
          end
        end else begin
          cnt <= cnt + 4'd1;
        end
      end
    end
  end

  wire [63:0] abytes = {adr2, adr1};

  assign nand_cle   = (phase == P_CMD1) || (phase == P_CMD2);
  assign nand_ale   = (phase == P_ADDR);
  assign nand_we_n  = !(is_wr && !hi);
  assign nand_re_n  = !(is_rd && !hi);
  assign nand_dq_oe = is_wr;
  assign nand_dq_o  = (phase == P_CMD1) ? opc1 :
                      (phase == P_CMD2) ? opc2 :
                      (phase == P_ADDR) ? abytes[{bidx, 3'b000} +: 8] :
                                          hold[{bidx[1:0], 3'b000} +: 8];
  assign nand_ce_n  = busy ? ~(NCE'(1) << cmd_q[16 +: CSW]) : '1;
  assign irq        = done_q && ien[0] && ien[1];

  always_comb begin
    case (reg_addr)
      RAW'(0): reg_rdata = cmd_q;
      RAW'(1): reg_rdata = {30'd0, done_q, busy};
      RAW'(2): reg_rdata = {30'd0, ien};
      RAW'(3): reg_rdata = {12'd0, tim1};
      RAW'(4): reg_rdata = {28'd0, tim2};
      RAW'(5): reg_rdata = {24'd0, opc1};
      RAW'(6): reg_rdata = {24'd0, opc2};
      RAW'(7): reg_rdata = adr1;
      RAW'(8): reg_rdata = adr2;
      RAW'(9): reg_rdata = hold;
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_ce_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_latch_needs_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale || !nand_we_n || !nand_re_n) |-> !(&nand_ce_n));
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_dq_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy && reg_wdata == 32'd0) |=> (&nand_ce_n && nand_we_n && nand_re_n && $stable(done_q)));
  assert_done_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy);
endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
  localparam int NCE = 8;
  localparam logic [7:0]  OPC1 = 8'hA5, OPC2 = 8'h3C;
  localparam logic [31:0] ADR1 = 32'h44332211, ADR2 = 32'h88776655, HOLD = 32'hDDCCBBAA;
  localparam int WL = 2, WH = 1, RL = 3, RH = 0, TWB = 4, TADL = 6;
  localparam int NV = 7;
  localparam logic [31:0] VCMD [NV] = '{32'hC000_0000, 32'hE503_0002, 32'hFF35_0004,
                                        32'h9817_0000, 32'hA001_0007, 32'hC600_0000,
                                        32'hD422_0000};
  localparam int VCNT [NV] = '{1, 5, 11, 2, 8, 2, 2};

  logic clk = 0, rst_n = 0, reg_wr = 0, nand_rdy = 1;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [NCE-1:0] nand_ce_n;
  logic [7:0] nand_dq_o, nand_dq_i;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nand_cmd_seq #(.NCE(NCE), .RAW(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy));

  logic [9:0] wlog [16];
  logic [NCE-1:0] wce [16];
  int wgap [16], wlow [16], rlow [8], rgap [8];
  int wn = 0, rn = 0, lowc = 0, since = 0, rcount = 0;
  logic pwe = 1, pre = 1;
  assign nand_dq_i = 8'hE0 + 8'(rcount);

  always @(negedge clk) begin
    if (!nand_we_n) begin
      if (pwe) begin
        if (wn < 16) begin wlog[wn] = {nand_cle, nand_ale, nand_dq_o}; wgap[wn] = since; wce[wn] = nand_ce_n; end
        lowc = 1;
      end else lowc++;
    end else if (!pwe) begin
      if (wn < 16) wlow[wn] = lowc;
      wn++; since = 1;
    end
    if (!nand_re_n) begin
      if (pre) begin if (rn < 8) rgap[rn] = since; lowc = 1; end
      else lowc++;
    end else if (!pre) begin
      if (rn < 8) rlow[rn] = lowc;
      rn++; rcount++; since = 1;
    end
    if (nand_we_n && nand_re_n && pwe && pre) since++;
    pwe = nand_we_n; pre = nand_re_n;
  end

  logic [9:0] exp_ev [16];
  logic exp_gx [16];

  function automatic int model(input logic [31:0] c);
    int n = 0;
    logic [63:0] ab = {ADR2, ADR1};
    logic late = c[25];
    logic adl = c[29] && (late || (!c[26] && !c[24]));
    for (int i = 0; i < 16; i++) exp_gx[i] = 0;
    if (c[30]) begin exp_ev[n] = {2'b10, OPC1}; n++; end
    if (c[29]) for (int i = 0; i <= int'(c[2:0]); i++) begin exp_ev[n] = {2'b01, ab[8*i +: 8]}; n++; end
    if (!late && c[26]) begin exp_ev[n] = {2'b10, OPC2}; n++; end
    if (c[28] && c[27]) for (int i = 0; i <= int'(c[21:20]); i++) begin
      exp_ev[n] = {2'b00, HOLD[8*i +: 8]}; exp_gx[n] = (i == 0) && adl; n++;
    end
    if (late && c[26]) begin exp_ev[n] = {2'b10, OPC2}; n++; end
    return n;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", what, act, expv); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 4'(a); #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin rd(1, s); if (!s[0]) break; @(negedge clk); end
  endtask

  task automatic clear_log();
    wn = 0; rn = 0; since = 0; rcount = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int k, n;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(1, s);
    chk(s == 0 && &nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !irq,
        "R6/R9 reset idle state", {s[7:0], 8'(nand_ce_n), 8'({nand_we_n, nand_re_n}), 8'(irq)}, 32'h00FF0300);

    wr(3, 32'(WL | (WH << 4) | (RL << 8) | (RH << 12) | (TWB << 16)));
    wr(4, 32'(TADL));
    wr(5, 32'(OPC1)); wr(6, 32'(OPC2)); wr(7, ADR1); wr(8, ADR2); wr(9, HOLD);

    for (int v = 0; v < NV; v++) begin
      clear_log();
      wr(0, VCMD[v]);
      wait_idle();
      repeat (2) @(negedge clk);
      n = model(VCMD[v]);
      chk(wn == VCNT[v] && n == VCNT[v], $sformatf("R1/R2/R3 vector %0d strobe count", v), 32'(wn), 32'(VCNT[v]));
      ok = 1;
      for (int e = 0; e < n && e < 16; e++) if (wlog[e] !== exp_ev[e]) ok = 0;
      chk(ok, $sformatf("R1/R2/R3/R4/R5 vector %0d byte trace", v), 32'(wlog[n > 0 ? n-1 : 0]), 32'(exp_ev[n > 0 ? n-1 : 0]));
      ok = 1;
      for (int e = 0; e < n && e < 16; e++) if (wce[e] !== ~(8'(1) << VCMD[v][18:16])) ok = 0;
      chk(ok, $sformatf("R6 vector %0d chip enable", v), 32'(wce[0]), 32'(~(8'(1) << VCMD[v][18:16])));
      ok = 1;
      for (int e = 0; e < n && e < 16; e++) begin
        if (wlow[e] != WL + 1) ok = 0;
        if (e > 0 && !exp_gx[e] && wgap[e] != WH + 1) ok = 0;
      end
      chk(ok, $sformatf("R8 vector %0d write pulse timing", v), 32'(wlow[0]), 32'(WL + 1));
      for (int e = 1; e < n && e < 16; e++)
        if (exp_gx[e]) chk(wgap[e] == WH + 1 + TADL + 1, "R12 address-to-data gap", 32'(wgap[e]), 32'(WH + TADL + 2));
      rd(1, s);
      chk(s[1:0] == 2'b10, $sformatf("R9 vector %0d done set", v), s, 32'h2);
      wr(1, 32'h2);
      rd(1, s);
      chk(s[1] == 0, "R9 done cleared by writing one", s, 32'h0);
    end
    chk(rn == 3, "R5 receive strobe count", 32'(rn), 32'd3);
    ok = 1;
    for (int e = 0; e < 3; e++) begin
      if (rlow[e] != RL + 1) ok = 0;
      if (e > 0 && rgap[e] != RH + 1) ok = 0;
    end
    chk(ok, "R8 read pulse timing", 32'(rlow[0]), 32'(RL + 1));
    rd(9, s);
    chk(s == 32'hDDE2E1E0, "R5 receive packing", s, 32'hDDE2E1E0);
    wr(9, HOLD);

    clear_log();
    wr(0, 32'hC100_0000);
    while (nand_we_n == 0) @(negedge clk);
    k = 0;
    rd(1, s);
    while (!s[1] && k < 100) begin @(negedge clk); k++; rd(1, s); end
    chk(k == (WH + 1) + (TWB + 1) + 1, "R7 busy-wait delay", 32'(k), 32'((WH + 1) + (TWB + 1) + 1));
    wr(1, 32'h2);

    nand_rdy = 0;
    wr(0, 32'hC100_0000);
    repeat (50) @(negedge clk);
    rd(1, s);
    chk(s[1:0] == 2'b01, "R7/R11 held busy while not ready", s, 32'h1);
    wr(5, 32'h0000_0011);
    rd(5, s);
    chk(s == 32'(OPC1), "R11 opcode write ignored while busy", s, 32'(OPC1));
    wr(9, 32'h1234_5678);
    rd(9, s);
    chk(s == HOLD, "R11 holding write ignored while busy", s, HOLD);
    k = wn;
    wr(0, 32'hC000_0000);
    repeat (10) @(negedge clk);
    rd(0, s);
    chk(s == 32'hC100_0000 && wn == k, "R11 command write ignored while busy", s, 32'hC100_0000);
    nand_rdy = 1;
    repeat (3) @(negedge clk);
    rd(1, s);
    chk(s[1:0] == 2'b10, "R7 completes once ready", s, 32'h2);

    chk(irq == 0, "R9 irq low with enables clear", 32'(irq), 0);
    wr(2, 32'h2);
    chk(irq == 0, "R9 irq low without global enable", 32'(irq), 0);
    wr(2, 32'h1);
    chk(irq == 0, "R9 irq low without done enable", 32'(irq), 0);
    wr(2, 32'h3);
    chk(irq == 1, "R9 irq high with both enables", 32'(irq), 1);
    wr(1, 32'h2);
    chk(irq == 0, "R9 irq low after clear", 32'(irq), 0);

    wr(0, 32'hA001_0007);
    repeat (4) @(negedge clk);
    wr(0, 32'h0);
    rd(1, s);
    chk(s[1:0] == 2'b00 && &nand_ce_n && nand_we_n && nand_re_n && !nand_ale,
        "R10 abort returns to idle", {s[15:0], 8'(nand_ce_n), 8'(nand_we_n)}, 32'h0000FF01);
    repeat (20) @(negedge clk);
    rd(1, s);
    chk(s[1] == 0 && irq == 0, "R10 no completion after abort", s, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule